// File: doc/BRIEF.md
# Video Memory Write Queue

This block holds a short queue of pending writes aimed at three video memories: a byte-addressed main video RAM, a 16-bit color table and a 16-bit vertical-scroll table. The CPU or DMA side pushes an entry, and the block stamps it with a due cycle. It then holds the entry until a free access slot comes at or after that cycle. Then it drives the memory write port that the entry's command code selects.

The hold time depends on the display mode. A fixed number of access slots is converted into clocks at 16 clocks per slot in the wide mode and 20 clocks per slot in the narrow mode. A write to the main video RAM is a byte operation. An entry with a full-word tag is drained in two passes: the upper byte goes to the entry address, and in the next slot the lower byte goes to the address with bit 0 inverted. Entries with a partial tag need only the second pass. The tag then selects which byte of the value is written.

Top module: `vwr_fifo`

## Requirements
- R1: After reset, `empty_o` is 1, `full_o` is 0 and no write strobe is high.
- R2: An entry accepted on a clock edge where `cycle_i` is C is written on the edge where `cycle_i` first equals C + LAT_SLOTS*20 (narrow, `wide_i`=0) or C + LAT_SLOTS*16 (wide, `wide_i`=1). The strobe is visible after that edge.
- R3: At most one write strobe is high per clock. A write happens only on an edge where `slot_i` was high and the head entry was due.
- R4: Entries are written in the order in which they were accepted.
- R5: `full_o` is high while DEPTH entries are held. A push offered while `full_o` is high is dropped.
- R6: `empty_o` falls after a push into an empty queue. It rises when the last entry is removed.
- R7: A main video RAM entry with tag 0 makes two writes in successive slots: value[15:8] to the entry address, then value[7:0] to the address XOR 1.
- R8: A main video RAM entry with tag 1 writes value[7:0] to the address XOR 1. With tag 2 it writes value[15:8] to the address XOR 1. Each is a single write.
- R9: A color table entry writes the full value at index (address >> 1) modulo CRAM_SIZE.
- R10: A scroll table entry writes the full value at index (address >> 1) AND 63. It is removed without a write when that index is not below VSRAM_SIZE.
- R11: Command code 1 selects main video RAM, 3 the color table and 5 the scroll table. Any other code is removed with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_i | input | CYCLE_W | Free-running cycle count |
| wide_i | input | 1 | Wide display mode (16 clocks per slot) |
| slot_i | input | 1 | Access slot available for a drain |
| push_i | input | 1 | Push request |
| push_addr_i | input | ADDR_W | Target address |
| push_val_i | input | 16 | Value to write |
| push_cmd_i | input | 4 | Command code |
| push_tag_i | input | 2 | Partial tag (0 full word, 1 low byte, 2 high byte) |
| full_o | output | 1 | Queue holds DEPTH entries |
| empty_o | output | 1 | Queue holds nothing |
| vram_we_o | output | 1 | Main video RAM byte write strobe |
| vram_addr_o | output | ADDR_W | Byte address |
| vram_data_o | output | 8 | Byte data |
| cram_we_o | output | 1 | Color table write strobe |
| cram_addr_o | output | $clog2(CRAM_SIZE) | Color table index |
| cram_data_o | output | 16 | Color table data |
| vsram_we_o | output | 1 | Scroll table write strobe |
| vsram_addr_o | output | 6 | Scroll table index |
| vsram_data_o | output | 16 | Scroll table data |

## Verification
A corrupted stored due cycle moves a write away from its expected cycle, and the error shows in the first drain of that entry. A read pointer that drifts shows up as writes out of order, or with the wrong target or data, at the next drain. A stuck high-byte phase bit leaves the low byte of a full-word write missing or repeated, one slot after the high byte. A fault in the full or empty logic shows directly on `full_o` and `empty_o`, one clock after the push or removal that should have changed them.

// File: rtl/vwr_pkg.sv
package vwr_pkg;
  localparam logic [3:0] CMD_VRAM  = 4'd1;
  localparam logic [3:0] CMD_CRAM  = 4'd3;
  localparam logic [3:0] CMD_VSRAM = 4'd5;

  typedef enum logic [1:0] {
    TAG_WORD = 2'd0,
    TAG_LO   = 2'd1,
    TAG_HI   = 2'd2,
    TAG_RSV  = 2'd3
  } tag_t;

  localparam int SLOT_CLK_WIDE   = 16;
  localparam int SLOT_CLK_NARROW = 20;
endpackage

// File: rtl/vwr_due_calc.sv
module vwr_due_calc #(
  parameter int CYCLE_W   = 24,
  parameter int LAT_SLOTS = 2
) (
  input  logic [CYCLE_W-1:0] cycle_i,
  input  logic               wide_i,
  output logic [CYCLE_W-1:0] due_o
);
  import vwr_pkg::*;
  localparam int LAT_WIDE   = LAT_SLOTS * SLOT_CLK_WIDE;
  localparam int LAT_NARROW = LAT_SLOTS * SLOT_CLK_NARROW;
  localparam logic [CYCLE_W-1:0] ADD_WIDE   = CYCLE_W'(LAT_WIDE);
  localparam logic [CYCLE_W-1:0] ADD_NARROW = CYCLE_W'(LAT_NARROW);

  always_comb begin
    due_o = cycle_i + (wide_i ? ADD_WIDE : ADD_NARROW);
  end
endmodule

// File: rtl/vwr_store.sv
module vwr_store #(
  parameter int DEPTH   = 4,
  parameter int CYCLE_W = 24,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push_i,
  input  logic [CYCLE_W-1:0] push_due_i,
  input  logic [ADDR_W-1:0]  push_addr_i,
  input  logic [15:0]        push_val_i,
  input  logic [3:0]         push_cmd_i,
  input  logic [1:0]         push_tag_i,
  input  logic               pop_i,
  output logic [CYCLE_W-1:0] head_due_o,
  output logic [ADDR_W-1:0]  head_addr_o,
  output logic [15:0]        head_val_o,
  output logic [3:0]         head_cmd_o,
  output logic [1:0]         head_tag_o,
  output logic               empty_o,
  output logic               full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] PTR_ONE = PW'(1);

  logic [CYCLE_W-1:0] due_mem  [DEPTH];
  logic [ADDR_W-1:0]  addr_mem [DEPTH];
  logic [15:0]        val_mem  [DEPTH];
  logic [3:0]         cmd_mem  [DEPTH];
  logic [1:0]         tag_mem  [DEPTH];

  logic [PW-1:0] wr_q, rd_q;
  logic          empty_q;
  logic          push_ok;
  logic [PW-1:0] rd_inc;

  assign full_o  = !empty_q && (wr_q == rd_q);
  assign empty_o = empty_q;
  assign push_ok = push_i && !full_o;
  assign rd_inc  = rd_q + PTR_ONE;

  // entry storage: single write port, no reset, so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) begin
      due_mem[wr_q]  <= push_due_i;
      addr_mem[wr_q] <= push_addr_i;
      val_mem[wr_q]  <= push_val_i;
      cmd_mem[wr_q]  <= push_cmd_i;
      tag_mem[wr_q]  <= push_tag_i;
    end
  end

  assign head_due_o  = due_mem[rd_q];
  assign head_addr_o = addr_mem[rd_q];
  assign head_val_o  = val_mem[rd_q];
  assign head_cmd_o  = cmd_mem[rd_q];
  assign head_tag_o  = tag_mem[rd_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= '0;
      rd_q    <= '0;
      empty_q <= 1'b1;
    end else begin
      if (push_ok) wr_q <= wr_q + PTR_ONE;
      if (push_ok && empty_q) begin
        rd_q    <= wr_q;
        empty_q <= 1'b0;
      end else if (pop_i) begin
        rd_q <= rd_inc;
        if (!push_ok && (rd_inc == wr_q)) empty_q <= 1'b1;
      end
    end
  end

  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (full_o && push_i) |=> $stable(wr_q)); // R5
  AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (rst)
    (push_i && !full_o) |=> !empty_o); // R6
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    empty_q |-> !pop_i); // R3
endmodule

// File: rtl/vwr_drain.sv
module vwr_drain #(
  parameter int CYCLE_W    = 24,
  parameter int ADDR_W     = 16,
  parameter int CRAM_SIZE  = 64,
  parameter int VSRAM_SIZE = 40
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         slot_i,
  input  logic [CYCLE_W-1:0]           cycle_i,
  input  logic                         empty_i,
  input  logic [CYCLE_W-1:0]           head_due_i,
  input  logic [ADDR_W-1:0]            head_addr_i,
  input  logic [15:0]                  head_val_i,
  input  logic [3:0]                   head_cmd_i,
  input  logic [1:0]                   head_tag_i,
  output logic                         pop_o,
  output logic                         vram_we_o,
  output logic [ADDR_W-1:0]            vram_addr_o,
  output logic [7:0]                   vram_data_o,
  output logic                         cram_we_o,
  output logic [$clog2(CRAM_SIZE)-1:0] cram_addr_o,
  output logic [15:0]                  cram_data_o,
  output logic                         vsram_we_o,
  output logic [5:0]                   vsram_addr_o,
  output logic [15:0]                  vsram_data_o
);
  import vwr_pkg::*;
  localparam int CAW = $clog2(CRAM_SIZE);
  localparam logic [6:0] VS_LIMIT = 7'(VSRAM_SIZE);

  logic [CYCLE_W-1:0] wait_diff;
  logic               due_ok;
  logic               hi_done_q;
  logic               set_hi;
  logic [CAW-1:0]     cram_idx;
  logic [5:0]         vs_idx;
  logic               vram_w, cram_w, vs_w;
  logic [ADDR_W-1:0]  vram_a;
  logic [7:0]         vram_d;

  // wrap-safe "cycle reached due" test: sign of the difference
  assign wait_diff = cycle_i - head_due_i;
  assign due_ok    = slot_i && !empty_i && !wait_diff[CYCLE_W-1];
  assign cram_idx  = head_addr_i[CAW:1];
  assign vs_idx    = head_addr_i[6:1];

  always_comb begin
    pop_o  = 1'b0;
    set_hi = 1'b0;
    vram_w = 1'b0;
    cram_w = 1'b0;
    vs_w   = 1'b0;
    vram_a = head_addr_i;
    vram_d = head_val_i[15:8];
    if (due_ok) begin
      unique case (head_cmd_i)
        CMD_VRAM: begin
          vram_w = 1'b1;
          if (head_tag_i == TAG_WORD && !hi_done_q) begin
            set_hi = 1'b1;
          end else begin
            vram_a = head_addr_i ^ ADDR_W'(1);
            vram_d = (head_tag_i == TAG_HI) ? head_val_i[15:8] : head_val_i[7:0];
            pop_o  = 1'b1;
          end
        end
        CMD_CRAM: begin
          cram_w = 1'b1;
          pop_o  = 1'b1;
        end
        CMD_VSRAM: begin
          vs_w  = ({1'b0, vs_idx} < VS_LIMIT);
          pop_o = 1'b1;
        end
        default: pop_o = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         hi_done_q <= 1'b0;
    else if (pop_o)  hi_done_q <= 1'b0;
    else if (set_hi) hi_done_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vram_we_o    <= 1'b0;
      vram_addr_o  <= '0;
      vram_data_o  <= '0;
      cram_we_o    <= 1'b0;
      cram_addr_o  <= '0;
      cram_data_o  <= '0;
      vsram_we_o   <= 1'b0;
      vsram_addr_o <= '0;
      vsram_data_o <= '0;
    end else begin
      vram_we_o    <= vram_w;
      vram_addr_o  <= vram_a;
      vram_data_o  <= vram_d;
      cram_we_o    <= cram_w;
      cram_addr_o  <= cram_idx;
      cram_data_o  <= head_val_i;
      vsram_we_o   <= vs_w;
      vsram_addr_o <= vs_idx;
      vsram_data_o <= head_val_i;
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0({vram_we_o, cram_we_o, vsram_we_o})); // R3
  AST_WRITE_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
    (vram_we_o || cram_we_o || vsram_we_o) |-> $past(slot_i)); // R3
  AST_VSRAM_RANGE: assert property (@(posedge clk) disable iff (rst)
    vsram_we_o |-> ({1'b0, vsram_addr_o} < VS_LIMIT)); // R10
  AST_HIGH_THEN_LOW: assert property (@(posedge clk) disable iff (rst)
    (set_hi && !pop_o) |=> hi_done_q); // R7
endmodule

// File: rtl/vwr_fifo.sv
module vwr_fifo #(
  parameter int DEPTH      = 4,
  parameter int CYCLE_W    = 24,
  parameter int ADDR_W     = 16,
  parameter int LAT_SLOTS  = 2,
  parameter int CRAM_SIZE  = 64,
  parameter int VSRAM_SIZE = 40
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CYCLE_W-1:0]           cycle_i,
  input  logic                         wide_i,
  input  logic                         slot_i,
  input  logic                         push_i,
  input  logic [ADDR_W-1:0]            push_addr_i,
  input  logic [15:0]                  push_val_i,
  input  logic [3:0]                   push_cmd_i,
  input  logic [1:0]                   push_tag_i,
  output logic                         full_o,
  output logic                         empty_o,
  output logic                         vram_we_o,
  output logic [ADDR_W-1:0]            vram_addr_o,
  output logic [7:0]                   vram_data_o,
  output logic                         cram_we_o,
  output logic [$clog2(CRAM_SIZE)-1:0] cram_addr_o,
  output logic [15:0]                  cram_data_o,
  output logic                         vsram_we_o,
  output logic [5:0]                   vsram_addr_o,
  output logic [15:0]                  vsram_data_o
);
  logic [CYCLE_W-1:0] push_due;
  logic [CYCLE_W-1:0] head_due;
  logic [ADDR_W-1:0]  head_addr;
  logic [15:0]        head_val;
  logic [3:0]         head_cmd;
  logic [1:0]         head_tag;
  logic               pop;
  logic               empty_w;

  vwr_due_calc #(.CYCLE_W(CYCLE_W), .LAT_SLOTS(LAT_SLOTS)) due_i (
    .cycle_i (cycle_i),
    .wide_i  (wide_i),
    .due_o   (push_due)
  );

  vwr_store #(.DEPTH(DEPTH), .CYCLE_W(CYCLE_W), .ADDR_W(ADDR_W)) store_i (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push_i),
    .push_due_i  (push_due),
    .push_addr_i (push_addr_i),
    .push_val_i  (push_val_i),
    .push_cmd_i  (push_cmd_i),
    .push_tag_i  (push_tag_i),
    .pop_i       (pop),
    .head_due_o  (head_due),
    .head_addr_o (head_addr),
    .head_val_o  (head_val),
    .head_cmd_o  (head_cmd),
    .head_tag_o  (head_tag),
    .empty_o     (empty_w),
    .full_o      (full_o)
  );

  assign empty_o = empty_w;

  vwr_drain #(.CYCLE_W(CYCLE_W), .ADDR_W(ADDR_W), .CRAM_SIZE(CRAM_SIZE),
              .VSRAM_SIZE(VSRAM_SIZE)) drain_i (
    .clk          (clk),
    .rst          (rst),
    .slot_i       (slot_i),
    .cycle_i      (cycle_i),
    .empty_i      (empty_w),
    .head_due_i   (head_due),
    .head_addr_i  (head_addr),
    .head_val_i   (head_val),
    .head_cmd_i   (head_cmd),
    .head_tag_i   (head_tag),
    .pop_o        (pop),
    .vram_we_o    (vram_we_o),
    .vram_addr_o  (vram_addr_o),
    .vram_data_o  (vram_data_o),
    .cram_we_o    (cram_we_o),
    .cram_addr_o  (cram_addr_o),
    .cram_data_o  (cram_data_o),
    .vsram_we_o   (vsram_we_o),
    .vsram_addr_o (vsram_addr_o),
    .vsram_data_o (vsram_data_o)
  );

  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !(full_o && empty_o)); // R5
endmodule

// File: tb/vwr_fifo_tb_top.sv
module vwr_fifo_tb_top;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] cyc = '0;
  logic        wide_i = 1'b0, slot_i = 1'b1, push_i = 1'b0;
  logic [15:0] push_addr_i = '0, push_val_i = '0;
  logic [3:0]  push_cmd_i = '0;
  logic [1:0]  push_tag_i = '0;
  logic        full_o, empty_o;
  logic        vram_we_o, cram_we_o, vsram_we_o;
  logic [15:0] vram_addr_o, cram_data_o, vsram_data_o;
  logic [7:0]  vram_data_o;
  logic [5:0]  cram_addr_o, vsram_addr_o;

  always #5 clk = ~clk;

  vwr_fifo dut_i (
    .clk(clk), .rst(rst), .cycle_i(cyc), .wide_i(wide_i), .slot_i(slot_i),
    .push_i(push_i), .push_addr_i(push_addr_i), .push_val_i(push_val_i),
    .push_cmd_i(push_cmd_i), .push_tag_i(push_tag_i),
    .full_o(full_o), .empty_o(empty_o),
    .vram_we_o(vram_we_o), .vram_addr_o(vram_addr_o), .vram_data_o(vram_data_o),
    .cram_we_o(cram_we_o), .cram_addr_o(cram_addr_o), .cram_data_o(cram_data_o),
    .vsram_we_o(vsram_we_o), .vsram_addr_o(vsram_addr_o), .vsram_data_o(vsram_data_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [23:0] edge_cyc;
  int  log_n;
  int  log_kind [16];
  int  log_addr [16];
  int  log_data [16];
  int  log_cyc  [16];

  // kind: 0 none, 1 main video RAM, 2 color table, 3 scroll table
  typedef struct packed {
    logic [3:0]  cmd;
    logic [1:0]  tag;
    logic        wide;
    logic [15:0] addr;
    logic [15:0] val;
    logic [1:0]  kind;
    logic [15:0] eaddr;
    logic [15:0] edata;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'd5, 2'd0, 1'b0, 16'h0010, 16'h1234, 2'd3, 16'd8,     16'h1234}, // R10 R9-style index
    '{4'd5, 2'd0, 1'b0, 16'h0052, 16'h4444, 2'd0, 16'd0,     16'h0000}, // R10 index 41 dropped
    '{4'd5, 2'd0, 1'b0, 16'h00CE, 16'h7777, 2'd3, 16'd39,    16'h7777}, // R10 index 39 kept
    '{4'd3, 2'd0, 1'b0, 16'h0086, 16'hABCD, 2'd2, 16'd3,     16'hABCD}, // R9 modulo
    '{4'd1, 2'd1, 1'b0, 16'h1000, 16'h5A3C, 2'd1, 16'h1001,  16'h003C}, // R8 tag 1
    '{4'd1, 2'd2, 1'b0, 16'h2001, 16'h5A3C, 2'd1, 16'h2000,  16'h005A}, // R8 tag 2
    '{4'd0, 2'd0, 1'b0, 16'h0004, 16'h1111, 2'd0, 16'd0,     16'h0000}, // R11 unknown code
    '{4'd3, 2'd0, 1'b1, 16'h0002, 16'h0F0F, 2'd2, 16'd1,     16'h0F0F}  // R2 wide latency
  };

  task automatic tick;
    @(posedge clk);
    #3;
    edge_cyc = cyc;
    if (log_n < 16) begin
      if (vram_we_o) begin
        log_kind[log_n] = 1; log_addr[log_n] = int'(vram_addr_o);
        log_data[log_n] = int'(vram_data_o); log_cyc[log_n] = int'(edge_cyc); log_n++;
      end else if (cram_we_o) begin
        log_kind[log_n] = 2; log_addr[log_n] = int'(cram_addr_o);
        log_data[log_n] = int'(cram_data_o); log_cyc[log_n] = int'(edge_cyc); log_n++;
      end else if (vsram_we_o) begin
        log_kind[log_n] = 3; log_addr[log_n] = int'(vsram_addr_o);
        log_data[log_n] = int'(vsram_data_o); log_cyc[log_n] = int'(edge_cyc); log_n++;
      end
    end
    cyc = cyc + 24'd1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] c, input logic [1:0] t, input logic w,
                      input logic [15:0] a, input logic [15:0] v, output int at);
    push_cmd_i = c; push_tag_i = t; wide_i = w; push_addr_i = a; push_val_i = v;
    push_i = 1'b1;
    tick();
    at = int'(edge_cyc);
    push_i = 1'b0;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int c0;
    log_n = 0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check(empty_o == 1'b1, "R1", "empty", int'(empty_o), 1);
    check(full_o == 1'b0, "R1", "full", int'(full_o), 0);
    check({vram_we_o, cram_we_o, vsram_we_o} == 3'b0, "R1", "strobes",
          int'({vram_we_o, cram_we_o, vsram_we_o}), 0);

    // vector walk: R2 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      log_n = 0;
      push(VECS[i].cmd, VECS[i].tag, VECS[i].wide, VECS[i].addr, VECS[i].val, c0);
      check(empty_o == 1'b0, "R6", "empty after push", int'(empty_o), 0);
      repeat (50) tick();
      check(log_n == (VECS[i].kind != 0 ? 1 : 0), "R11", "write count", log_n,
            VECS[i].kind != 0 ? 1 : 0);
      if (VECS[i].kind != 0 && log_n > 0) begin
        check(log_kind[0] == int'(VECS[i].kind), "R11", "target", log_kind[0], int'(VECS[i].kind));
        check(log_addr[0] == int'(VECS[i].eaddr), "R9", "address", log_addr[0], int'(VECS[i].eaddr));
        check(log_data[0] == int'(VECS[i].edata), "R8", "data", log_data[0], int'(VECS[i].edata));
        check(log_cyc[0] == c0 + LAT * (VECS[i].wide ? 16 : 20), "R2", "due cycle",
              log_cyc[0], c0 + LAT * (VECS[i].wide ? 16 : 20));
      end
      check(empty_o == 1'b1, "R10", "entry removed", int'(empty_o), 1);
    end

    // R7 full-word main video RAM write
    log_n = 0;
    push(4'd1, 2'd0, 1'b0, 16'h0100, 16'hBEEF, c0);
    repeat (50) tick();
    check(log_n == 2, "R7", "write count", log_n, 2);
    check(log_addr[0] == 'h100 && log_data[0] == 'hBE, "R7", "high byte", log_data[0], 'hBE);
    check(log_addr[1] == 'h101 && log_data[1] == 'hEF, "R7", "low byte", log_data[1], 'hEF);
    check(log_cyc[0] == c0 + 40 && log_cyc[1] == c0 + 41, "R7", "phase cycles",
          log_cyc[1], c0 + 41);

    // R5 R4 R3: fill with slots withheld
    slot_i = 1'b0;
    log_n = 0;
    for (int k = 0; k < 4; k++) push(4'd3, 2'd0, 1'b0, 16'(2 * k), 16'(16'h100 + k), c0);
    check(full_o == 1'b1, "R5", "full after four", int'(full_o), 1);
    push(4'd3, 2'd0, 1'b0, 16'd20, 16'h0999, c0);
    check(full_o == 1'b1, "R5", "still full", int'(full_o), 1);
    repeat (60) tick();
    check(log_n == 0, "R3", "no write without slot", log_n, 0);
    slot_i = 1'b1;
    repeat (10) tick();
    check(log_n == 4, "R5", "extra push dropped", log_n, 4);
    for (int k = 0; k < 4; k++)
      check(log_addr[k] == k && log_data[k] == 'h100 + k, "R4", "order", log_addr[k], k);
    for (int k = 1; k < 4; k++)
      check(log_cyc[k] == log_cyc[k-1] + 1, "R3", "one per clock", log_cyc[k], log_cyc[k-1] + 1);
    check(empty_o == 1'b1 && full_o == 1'b0, "R6", "empty after drain", int'(empty_o), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule